// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Logic

This block is a bank of 32 general-purpose pins with a 32-bit memory-mapped register interface. Software sets each pin's output value and whether it drives (output) or only listens (input). It reads back the pad levels after a two-flop synchronizer. Every pin also feeds an interrupt source. For each pin, software can enable the source, mask it, choose level or edge sensitivity, and choose the active polarity. The bank exposes raw and masked status and accepts a write-one-to-clear acknowledge for latched edges. All masked sources are combined onto a single interrupt output.

Both-edge detection is not built in. Software gets it by flipping a pin's polarity after each event, with that pin's enable cleared while it writes the new polarity. The debounce and level-sync registers are stored and read back, but they change no behaviour. Writes take effect on the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe_o` and `pad_out_o` are 0 and `irq_o` is low.
- R2: The output register (offset 0x00) drives `pad_out_o` and the direction register (offset 0x04) drives `pad_oe_o`; a direction bit of 1 makes the pin an output and 0 makes it an input. Both read back as written.
- R3: The pin-level register (offset 0x50) returns `pad_in_i` delayed by two clock edges for every pin, including pins configured as outputs.
- R4: A pin whose edge-select bit (offset 0x38) is 0 is level-sensitive. With polarity bit (offset 0x3C) 1 it is active while the synchronized level is 1; with polarity bit 0 it is active while the level is 0. The status is not latched and follows the level.
- R5: A pin whose edge-select bit is 1 is edge-sensitive. Polarity 1 detects a rising edge and polarity 0 a falling edge of the synchronized level. A detected edge stays set in raw status until it is cleared.
- R6: Writing 1 to a bit of the acknowledge register (offset 0x4C) clears that pin's latched edge; bits written 0 have no effect. An edge detected in the same cycle as the acknowledge stays latched. The register reads 0.
- R7: A pin whose enable bit (offset 0x30) is 0 never shows in raw status, and clearing the enable discards a latched edge.
- R8: Raw status (offset 0x44) ignores the mask. Masked status (offset 0x40) equals raw status with every bit set in the mask register (offset 0x34) forced to 0.
- R9: `irq_o` is high exactly when masked status is non-zero.
- R10: The debounce register (offset 0x48) and level-sync register (offset 0x60) read back as written and do not change any status or output.
- R11: Reads of unmapped offsets return 0. Writes to the status and pin-level offsets (0x40, 0x44, 0x50) and to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pad_in_i | input | 32 | Pad levels seen by the bank |
| pad_out_o | output | 32 | Output value per pin |
| pad_oe_o | output | 32 | Output enable per pin (1 = drive) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- A disabled pin never appears in raw status.
- A latched edge survives until an acknowledge, a disable or a switch to level mode.
- An acknowledge without a coincident edge clears the latch.
- Masked status never carries a masked bit.
- The interrupt output is never high without a raw source.
- A direction write lands in the output enables.

Some properties only the bench's scenarios can show, against its behavioural model:
- The two-cycle synchronizer latency.
- The separation of rising and falling edges by polarity.
- The acknowledge racing a new edge.
- Level sources dropping as the pad returns.
- The debounce and level-sync registers having no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_OUT  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR  = 8'h04;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h30;
  localparam logic [ADDR_W-1:0] A_IMSK = 8'h34;
  localparam logic [ADDR_W-1:0] A_ISEL = 8'h38;
  localparam logic [ADDR_W-1:0] A_IPOL = 8'h3C;
  localparam logic [ADDR_W-1:0] A_MST  = 8'h40;
  localparam logic [ADDR_W-1:0] A_RAW  = 8'h44;
  localparam logic [ADDR_W-1:0] A_DBN  = 8'h48;
  localparam logic [ADDR_W-1:0] A_ACK  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_PIN  = 8'h50;
  localparam logic [ADDR_W-1:0] A_LSY  = 8'h60;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   out_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   ien_o,
  output logic [NPIN-1:0]   imsk_o,
  output logic [NPIN-1:0]   isel_o,
  output logic [NPIN-1:0]   ipol_o,
  output logic [NPIN-1:0]   dbn_o,
  output logic [NPIN-1:0]   lsy_o,
  output logic [NPIN-1:0]   ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= '0;
      dir_o  <= '0;
      ien_o  <= '0;
      imsk_o <= '0;
      isel_o <= '0;
      ipol_o <= '0;
      dbn_o  <= '0;
      lsy_o  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_OUT:   out_o  <= wdata_i;
        A_DIR:   dir_o  <= wdata_i;
        A_IEN:   ien_o  <= wdata_i;
        A_IMSK:  imsk_o <= wdata_i;
        A_ISEL:  isel_o <= wdata_i;
        A_IPOL:  ipol_o <= wdata_i;
        A_DBN:   dbn_o  <= wdata_i;
        A_LSY:   lsy_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  // acknowledge is a one-cycle pulse, never stored
  assign ack_o = (wr_en_i && addr_i == A_ACK) ? wdata_i : '0;

  p_oe_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR) |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pad_i,
  output logic [NPIN-1:0] sync_o,
  output logic [NPIN-1:0] prev_o
);
  logic [NPIN-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= pad_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= stg_q[STAGES-1];
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] ien_i,
  input  logic [NPIN-1:0] imsk_i,
  input  logic [NPIN-1:0] isel_i,
  input  logic [NPIN-1:0] ipol_i,
  input  logic [NPIN-1:0] ack_i,
  output logic [NPIN-1:0] raw_o,
  output logic [NPIN-1:0] masked_o,
  output logic            irq_o
);
  logic [NPIN-1:0] lvl_hit, edge_hit, latch_d, latch_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign lvl_hit[g]  = (sync_i[g] == ipol_i[g]);
    assign edge_hit[g] = (sync_i[g] != prev_i[g]) && (sync_i[g] == ipol_i[g]);
    // a fresh edge wins over a coincident acknowledge
    assign latch_d[g]  = ((latch_q[g] & ~ack_i[g]) | edge_hit[g]) & ien_i[g] & isel_i[g];
    assign raw_o[g]    = ien_i[g] & (isel_i[g] ? latch_q[g] : lvl_hit[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= latch_d;
  end

  assign masked_o = raw_o & ~imsk_i;
  assign irq_o    = |masked_o;

  p_raw_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o & ~ien_i) == '0);
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(latch_q) & $past(ien_i & isel_i & ~ack_i) & ~latch_q) == '0));
  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ack_i & ~edge_hit) & latch_q) == '0));
  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & imsk_i) == '0);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic              irq_o
);
  logic [NPIN-1:0] ien, imsk, isel, ipol, dbn, lsy, ack;
  logic [NPIN-1:0] sync, prev, raw, masked;

  gpio_bank_regs #(.NPIN(NPIN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .out_o(pad_out_o), .dir_o(pad_oe_o), .ien_o(ien), .imsk_o(imsk),
    .isel_o(isel), .ipol_o(ipol), .dbn_o(dbn), .lsy_o(lsy), .ack_o(ack)
  );

  gpio_bank_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pad_i(pad_in_i), .sync_o(sync), .prev_o(prev)
  );

  gpio_bank_irq #(.NPIN(NPIN)) u_irq (
    .clk_i, .rst_ni, .sync_i(sync), .prev_i(prev), .ien_i(ien),
    .imsk_i(imsk), .isel_i(isel), .ipol_i(ipol), .ack_i(ack),
    .raw_o(raw), .masked_o(masked), .irq_o(irq_o)
  );

  always_comb begin
    case (addr_i)
      A_OUT:   rdata_o = pad_out_o;
      A_DIR:   rdata_o = pad_oe_o;
      A_IEN:   rdata_o = ien;
      A_IMSK:  rdata_o = imsk;
      A_ISEL:  rdata_o = isel;
      A_IPOL:  rdata_o = ipol;
      A_MST:   rdata_o = masked;
      A_RAW:   rdata_o = raw;
      A_DBN:   rdata_o = dbn;
      A_PIN:   rdata_o = sync;
      A_LSY:   rdata_o = lsy;
      default: rdata_o = '0;
    endcase
  end

  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_we = 1'b0;
  logic [7:0]  b_addr = 8'h00;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_pad = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  gpio_irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(b_we), .addr_i(b_addr),
    .wdata_i(b_wdata), .rdata_o(rdata), .pad_in_i(b_pad),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // behavioural model
  logic [31:0] m_out, m_dir, m_en, m_msk, m_edg, m_pol, m_dbn, m_lsy, m_lat;
  logic [31:0] hist[$];

  task automatic model_reset();
    m_out = 0; m_dir = 0; m_en = 0; m_msk = 0; m_edg = 0; m_pol = 0;
    m_dbn = 0; m_lsy = 0; m_lat = 0;
    hist = {32'h0, 32'h0, 32'h0};
  endtask

  function automatic logic [31:0] m_raw();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (!m_en[i]) r[i] = 1'b0;
      else if (m_edg[i]) r[i] = m_lat[i];
      else r[i] = (hist[1][i] == m_pol[i]);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_out;
      8'h04: return m_dir;
      8'h30: return m_en;
      8'h34: return m_msk;
      8'h38: return m_edg;
      8'h3C: return m_pol;
      8'h40: return m_raw() & ~m_msk;
      8'h44: return m_raw();
      8'h48: return m_dbn;
      8'h50: return hist[1];
      8'h60: return m_lsy;
      default: return 32'h0;
    endcase
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [31:0] ackv, s2, pv;
      s2 = hist[1]; pv = hist[2];
      ackv = (b_we && b_addr == 8'h4C) ? b_wdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        logic hit;
        hit = (s2[i] != pv[i]) && (s2[i] == m_pol[i]);
        m_lat[i] = ((m_lat[i] & ~ackv[i]) | hit) & m_en[i] & m_edg[i];
      end
      if (b_we) begin
        case (b_addr)
          8'h00: m_out = b_wdata;
          8'h04: m_dir = b_wdata;
          8'h30: m_en  = b_wdata;
          8'h34: m_msk = b_wdata;
          8'h38: m_edg = b_wdata;
          8'h3C: m_pol = b_wdata;
          8'h48: m_dbn = b_wdata;
          8'h60: m_lsy = b_wdata;
          default: ;
        endcase
      end
      hist.push_front(b_pad);
      void'(hist.pop_back());
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (addr %h, t=%0t)",
               cur_req, what, act, exp, b_addr, $time);
    end
  endtask

  // compare every cycle, away from the edges
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rst_n) begin
      check("rdata", rdata, m_read(b_addr));
      check("pad_out R2", pad_out, m_out);
      check("pad_oe R2", pad_oe, m_dir);
      check("irq R9", {31'h0, irq}, {31'h0, ((m_raw() & ~m_msk) != 0)});
    end
  end

  initial begin
    @(posedge clk);
    while (cycles < 100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); b_we = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); b_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); b_addr = a;
    @(negedge clk);
  endtask

  task automatic pad(logic [31:0] v);
    @(negedge clk); b_pad = v;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  localparam logic [7:0] ADDRS [12] = '{8'h00, 8'h04, 8'h30, 8'h34, 8'h38, 8'h3C,
                                        8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h60};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int k = 0; k < 12; k++) rd(ADDRS[k]);

    cur_req = "R2";
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00);
    wr(8'h04, 32'hFFFF_0000); rd(8'h04);

    cur_req = "R3";
    b_addr = 8'h50;
    pad(32'h1234_5678); idle(1); pad(32'hFFFF_FFFF); idle(3);
    pad(32'h0000_FFFF); idle(3);

    cur_req = "R4";
    wr(8'h38, 32'h0000_0000);
    wr(8'h3C, 32'h0000_000F);
    wr(8'h30, 32'h0000_00FF);
    b_addr = 8'h44;
    pad(32'h0000_0000); idle(3);
    pad(32'h0000_0055); idle(3);
    pad(32'h0000_00FF); idle(3);
    pad(32'h0000_0000); idle(3);

    cur_req = "R5";
    wr(8'h30, 32'h0);
    wr(8'h3C, 32'h0000_0F00);
    wr(8'h38, 32'h0000_FF00);
    wr(8'h30, 32'h0000_FF00);
    b_addr = 8'h44;
    pad(32'h0000_FF00); idle(4);
    pad(32'h0000_0000); idle(4);
    rd(8'h40);

    cur_req = "R6";
    wr(8'h4C, 32'h0000_0300); rd(8'h44);
    wr(8'h4C, 32'h0000_0000); rd(8'h4C);
    for (int d = 0; d < 4; d++) begin
      pad(32'h0000_FF00);
      idle(d);
      wr(8'h4C, 32'h0000_FF00);
      rd(8'h44);
      pad(32'h0000_0000); idle(4);
      wr(8'h4C, 32'hFFFF_FFFF);
    end

    cur_req = "R7";
    pad(32'h0000_FF00); idle(4);
    wr(8'h30, 32'h0000_0F00); rd(8'h44);
    wr(8'h30, 32'h0000_FF00); rd(8'h44);

    cur_req = "R8";
    pad(32'h0000_0000); idle(4);
    wr(8'h34, 32'h0000_0F00); rd(8'h40); rd(8'h44);
    wr(8'h34, 32'h0000_FFFF); rd(8'h40);
    wr(8'h34, 32'h0);

    cur_req = "R9";
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h40);
    // both-edge emulation: flip polarity with enable off
    wr(8'h30, 32'h0);
    wr(8'h3C, 32'h0000_F000);
    wr(8'h30, 32'h0000_F000);
    pad(32'h0000_F000); idle(4);
    wr(8'h30, 32'h0);
    wr(8'h3C, 32'h0);
    wr(8'h30, 32'h0000_F000);
    pad(32'h0000_0000); idle(4);

    cur_req = "R10";
    wr(8'h48, 32'hDEAD_BEEF); rd(8'h48);
    wr(8'h60, 32'h0000_0001); rd(8'h60);
    b_addr = 8'h44;
    pad(32'h0000_F000); idle(4); pad(32'h0); idle(4);

    cur_req = "R11";
    rd(8'h08); rd(8'h5C); rd(8'hFC);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
    for (int k = 0; k < 12; k++) rd(ADDRS[k]);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule